// File: doc/BRIEF.md
# Flash Sector Erase Command Interpreter

This block sits on the device side of a parallel flash write/read bus. It decodes the multi-write sector erase command and collects the sectors picked for erasure in a bit vector. It then runs a counted stand-in for the erase itself. Once the command is complete, an acceptance window opens. During the window, single extra erase writes add sectors and restart the window. Any other write drops the collected set. When the window runs out without a new write, erasing starts and every write except suspend is ignored.

Suspend takes effect at once if it arrives during the window. If it arrives during the erase, it takes effect only after a bounded latency. While the block is suspended, reads of unselected sectors pass array data through, and reads of selected sectors return a status byte. A resume write carries on with the erase that remains. Each duration is a parameter in clock cycles: the window, the erase and the suspend latency. The reset is synchronous and active high, and it ends any operation at once.

Top module: `sector_erase_ctl`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to array read mode. After that edge `busy` is 0, `sel_vec` is 0 and reads return `array_data`.
- R2: The command is this sequence of writes: 0xAA to address 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 with the target in `sec`. After the sixth write, `busy` is 1 and only bit `sec` of `sel_vec` is set. A wrong write at any step before the sixth returns to read mode.
- R3: During the window, a write of 0x30 sets bit `sec` in `sel_vec` and reloads the window. After the last write, the window stays open for WINDOW_CYC cycles without writes, and erasing starts on the edge that follows.
- R4: During the window, a write whose data is neither 0x30 nor 0xB0 clears `sel_vec` and returns to read mode, and `busy` goes to 0.
- R5: Every read during the window, the erase or a pending suspend returns the status byte instead of array data. In that byte, bit 7 is 0. Bit 3 is 0 during the window and 1 once erasing has started. Bit 6 flips after every status read. Bit 2 flips after every status read of a selected sector. The other bits are 0.
- R6: While erasing, every write other than 0xB0 leaves `sel_vec` and `busy` unchanged.
- R7: A write of 0xB0 during the window enters the suspended state on the next edge, whatever the address. `busy` is then 0 and `sel_vec` keeps its value.
- R8: A write of 0xB0 during the erase keeps `busy` at 1 for SUSP_LAT cycles. The block is then suspended with `busy` at 0.
- R9: While suspended, reads of unselected sectors return `array_data`. Reads of selected sectors return the status byte with bit 3 at 1.
- R10: While suspended, a write of 0x30 resumes the erase with the remaining count, and `busy` returns to 1.
- R11: The erase lasts ERASE_CYC cycles, not counting time spent suspended. At the end, `sel_vec` clears and `busy` goes to 0.
- R12: A reset during an erase ends it on that edge and returns the block to read mode with `sel_vec` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Bus address used for unlock decode |
| sec | input | SEC_W | Sector index of the current access |
| wdata | input | 8 | Write data, carries the command code |
| array_data | input | 8 | Data read from the memory array |
| rdata | output | 8 | Read data: array data or status byte |
| busy | output | 1 | High during the window, the erase and a pending suspend |
| sel_vec | output | NSEC | One bit per sector selected for erasure |

## Verification
The erase command is driven in several forms. A correct sequence with one sector shows that decode works. A sequence that breaks at the third write shows that an unlock mismatch resets the decoder. Adding several sectors in non-ascending order shows the OR accumulation and the window restart. Reads are placed one cycle either side of the window expiry, and they show exactly where status bit 3 changes. Suspend is tried inside the window and during the erase. The two cases are told apart by how long `busy` stays high. Resume and a mid-erase reset are also covered, and a behavioural model checks every cycle throughout.

// File: rtl/sec_erase_pkg.sv
package sec_erase_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UL1,
        ST_UL2,
        ST_SETUP,
        ST_UL3,
        ST_UL4,
        ST_WIN,
        ST_ERASE,
        ST_PEND,
        ST_SUSP
    } sec_state_e;

    // classification of one bus write
    typedef struct packed {
        logic ul_a;
        logic ul_b;
        logic setup;
        logic erase;
        logic susp;
        logic resume;
    } wr_kind_t;

    localparam logic [7:0] CODE_UL_A   = 8'hAA;
    localparam logic [7:0] CODE_UL_B   = 8'h55;
    localparam logic [7:0] CODE_SETUP  = 8'h80;
    localparam logic [7:0] CODE_ERASE  = 8'h30;
    localparam logic [7:0] CODE_SUSP   = 8'hB0;
    localparam logic [7:0] CODE_RESUME = 8'h30;

    localparam int unsigned UL_ADDR_A = 'h555;
    localparam int unsigned UL_ADDR_B = 'h2AA;

    function automatic logic [7:0] status_byte(input logic t6, input logic dq3, input logic t2);
        return {1'b0, t6, 2'b00, dq3, t2, 2'b00};
    endfunction

    function automatic logic is_busy_state(input sec_state_e s);
        return (s == ST_WIN) || (s == ST_ERASE) || (s == ST_PEND);
    endfunction

endpackage

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
    import sec_erase_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output wr_kind_t          kind
);
    localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(UL_ADDR_A);
    localparam logic [ADDR_W-1:0] B_ADDR = ADDR_W'(UL_ADDR_B);

    always_comb begin
        kind.ul_a   = (addr == A_ADDR) && (wdata == CODE_UL_A);
        kind.ul_b   = (addr == B_ADDR) && (wdata == CODE_UL_B);
        kind.setup  = (addr == A_ADDR) && (wdata == CODE_SETUP);
        kind.erase  = (wdata == CODE_ERASE);
        kind.susp   = (wdata == CODE_SUSP);
        kind.resume = (wdata == CODE_RESUME);
    end
endmodule

// File: rtl/sec_erase_fsm.sv
module sec_erase_fsm
    import sec_erase_pkg::*;
#(
    parameter int unsigned NSEC       = 8,
    parameter int unsigned SEC_W      = 3,
    parameter int unsigned WINDOW_CYC = 10000,
    parameter int unsigned ERASE_CYC  = 20000,
    parameter int unsigned SUSP_LAT   = 7000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wr_kind_t         kind,
    input  logic [SEC_W-1:0] sec,
    output sec_state_e       st,
    output logic [NSEC-1:0]  sel_vec
);
    localparam int unsigned WW = $clog2(WINDOW_CYC + 1);
    localparam int unsigned EW = $clog2(ERASE_CYC + 1);
    localparam int unsigned SW = $clog2(SUSP_LAT + 1);
    localparam logic [WW-1:0] WIN_LOAD = WW'(WINDOW_CYC);
    localparam logic [EW-1:0] ERS_LOAD = EW'(ERASE_CYC);
    localparam logic [SW-1:0] SUS_LOAD = SW'(SUSP_LAT);

    logic [WW-1:0]   win_cnt;
    logic [EW-1:0]   ers_cnt;
    logic [SW-1:0]   sus_cnt;
    logic [NSEC-1:0] sec_bit;
    logic            ers_last;

    assign sec_bit  = {{(NSEC-1){1'b0}}, 1'b1} << sec;
    assign ers_last = (ers_cnt == EW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_READ;
            sel_vec <= '0;
            win_cnt <= '0;
            ers_cnt <= '0;
            sus_cnt <= '0;
        end else begin
            case (st)
                ST_READ:  if (wr_en && kind.ul_a) st <= ST_UL1;
                ST_UL1:   if (wr_en) st <= kind.ul_b  ? ST_UL2   : ST_READ;
                ST_UL2:   if (wr_en) st <= kind.setup ? ST_SETUP : ST_READ;
                ST_SETUP: if (wr_en) st <= kind.ul_a  ? ST_UL3   : ST_READ;
                ST_UL3:   if (wr_en) st <= kind.ul_b  ? ST_UL4   : ST_READ;
                ST_UL4: begin
                    if (wr_en) begin
                        if (kind.erase) begin
                            st      <= ST_WIN;
                            sel_vec <= sec_bit;
                            win_cnt <= WIN_LOAD;
                        end else begin
                            st <= ST_READ;
                        end
                    end
                end
                ST_WIN: begin
                    if (wr_en) begin
                        if (kind.erase) begin
                            sel_vec <= sel_vec | sec_bit;
                            win_cnt <= WIN_LOAD;
                        end else if (kind.susp) begin
                            st      <= ST_SUSP;
                            ers_cnt <= ERS_LOAD;
                        end else begin
                            st      <= ST_READ;
                            sel_vec <= '0;
                        end
                    end else if (win_cnt == WW'(1)) begin
                        st      <= ST_ERASE;
                        ers_cnt <= ERS_LOAD;
                    end else begin
                        win_cnt <= win_cnt - WW'(1);
                    end
                end
                ST_ERASE: begin
                    if (ers_last) begin
                        st      <= ST_READ;
                        sel_vec <= '0;
                    end else begin
                        ers_cnt <= ers_cnt - EW'(1);
                        if (wr_en && kind.susp) begin
                            st      <= ST_PEND;
                            sus_cnt <= SUS_LOAD;
                        end
                    end
                end
                ST_PEND: begin
                    if (ers_last) begin
                        st      <= ST_READ;
                        sel_vec <= '0;
                    end else begin
                        ers_cnt <= ers_cnt - EW'(1);
                        if (sus_cnt == SW'(1)) st <= ST_SUSP;
                        else                   sus_cnt <= sus_cnt - SW'(1);
                    end
                end
                ST_SUSP:  if (wr_en && kind.resume) st <= ST_ERASE;
                default:  st <= ST_READ;
            endcase
        end
    end
endmodule

// File: rtl/sec_status_read.sv
module sec_status_read
    import sec_erase_pkg::*;
#(
    parameter int unsigned NSEC  = 8,
    parameter int unsigned SEC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  sec_state_e       st,
    input  logic [NSEC-1:0]  sel_vec,
    input  logic [SEC_W-1:0] sec,
    input  logic [7:0]       array_data,
    output logic [7:0]       rdata
);
    logic tog6, tog2, hit_sel, show, dq3;

    assign hit_sel = sel_vec[sec];
    assign dq3     = (st == ST_ERASE) || (st == ST_PEND) || (st == ST_SUSP);
    assign show    = rd_en && (is_busy_state(st) || ((st == ST_SUSP) && hit_sel));
    assign rdata   = show ? status_byte(tog6, dq3, tog2) : array_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else if (show) begin
            tog6 <= ~tog6;
            if (hit_sel) tog2 <= ~tog2;
        end
    end
endmodule

// File: rtl/sector_erase_ctl.sv
module sector_erase_ctl
    import sec_erase_pkg::*;
#(
    parameter int unsigned NSEC       = 8,
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned WINDOW_CYC = 10000,
    parameter int unsigned ERASE_CYC  = 20000,
    parameter int unsigned SUSP_LAT   = 7000,
    localparam int unsigned SEC_W     = (NSEC > 1) ? $clog2(NSEC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEC_W-1:0]  sec,
    input  logic [7:0]        wdata,
    input  logic [7:0]        array_data,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic [NSEC-1:0]   sel_vec
);
    wr_kind_t   kind;
    sec_state_e st;

    sec_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (addr),
        .wdata (wdata),
        .kind  (kind)
    );

    sec_erase_fsm #(
        .NSEC(NSEC), .SEC_W(SEC_W), .WINDOW_CYC(WINDOW_CYC),
        .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .kind    (kind),
        .sec     (sec),
        .st      (st),
        .sel_vec (sel_vec)
    );

    sec_status_read #(.NSEC(NSEC), .SEC_W(SEC_W)) u_stat (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .st         (st),
        .sel_vec    (sel_vec),
        .sec        (sec),
        .array_data (array_data),
        .rdata      (rdata)
    );

    assign busy = is_busy_state(st);
endmodule

// File: rtl/sector_erase_chk.sv
module sector_erase_chk
    import sec_erase_pkg::*;
#(
    parameter int unsigned NSEC  = 8,
    parameter int unsigned SEC_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en,
    input logic [SEC_W-1:0] sec,
    input logic [7:0]       array_data,
    input logic [7:0]       rdata,
    input logic             busy,
    input logic [NSEC-1:0]  sel_vec,
    input sec_state_e       st
);
    // R1
    rst_clears_chk: assert property (@(posedge clk) rst |=> (!busy && sel_vec == '0));

    // R5
    window_dq3_low_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && st == ST_WIN) |-> (rdata[3] == 1'b0 && rdata[7] == 1'b0));

    // R6
    erase_sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERASE) |=> (sel_vec == $past(sel_vec) || sel_vec == '0));

    // R8
    pend_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PEND) |-> busy);

    // R9
    susp_array_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && st == ST_SUSP && !sel_vec[sec]) |-> (rdata == array_data));

    // R11
    busy_drop_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (sel_vec == '0 || st == ST_SUSP));
endmodule

bind sector_erase_ctl sector_erase_chk #(.NSEC(NSEC), .SEC_W(SEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .sec        (sec),
    .array_data (array_data),
    .rdata      (rdata),
    .busy       (busy),
    .sel_vec    (sel_vec),
    .st         (st)
);

// File: tb/sector_erase_ctl_bench.sv
`timescale 1ns/1ps
module sector_erase_ctl_bench;
    localparam int WIN = 12;
    localparam int ERS = 40;
    localparam int SUS = 5;

    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en;
    logic [10:0] addr;
    logic [2:0]  sec;
    logic [7:0]  wdata, array_data, rdata;
    logic        busy;
    logic [7:0]  sel_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // behavioural reference
    localparam int M_IDLE = 0, M_WIN = 1, M_ERASE = 2, M_PEND = 3, M_SUSP = 4;
    int         mode, step, mwin, mers, msus;
    logic [7:0] msel;
    bit         mt6, mt2;
    int         seq_a [6] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, -1};
    int         seq_d [6] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30};

    always #2.5 clk = ~clk;

    sector_erase_ctl #(.NSEC(8), .ADDR_W(11), .WINDOW_CYC(WIN), .ERASE_CYC(ERS), .SUSP_LAT(SUS))
    u_sector_erase_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .sec(sec),
        .wdata(wdata), .array_data(array_data), .rdata(rdata), .busy(busy), .sel_vec(sel_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_show();
        if (!rd_en) return 0;
        if (mode == M_WIN || mode == M_ERASE || mode == M_PEND) return 1;
        return (mode == M_SUSP) && msel[sec];
    endfunction

    function automatic logic [7:0] m_rdata();
        logic [7:0] v;
        if (!m_show()) return array_data;
        v = 8'h00;
        if (mt6) v = v | 8'h40;
        if (mode != M_WIN) v = v | 8'h08;
        if (mt2) v = v | 8'h04;
        return v;
    endfunction

    task automatic m_reset();
        mode = M_IDLE; step = 0; msel = 0; mt6 = 0; mt2 = 0; mwin = 0; mers = 0; msus = 0;
    endtask

    task automatic m_finish_erase();
        mode = M_IDLE; msel = 0;
    endtask

    task automatic model_step();
        if (rst) begin
            m_reset();
            return;
        end
        if (m_show()) begin
            mt6 = !mt6;
            if (msel[sec]) mt2 = !mt2;
        end
        if (mode == M_IDLE) begin
            if (wr_en) begin
                if ((seq_a[step] < 0 || int'(addr) == seq_a[step]) && int'(wdata) == seq_d[step]) begin
                    if (step == 5) begin
                        mode = M_WIN; msel = 8'(1) << sec; mwin = WIN; step = 0;
                    end else step++;
                end else step = 0;
            end
        end else if (mode == M_WIN) begin
            if (wr_en) begin
                if (wdata == 8'h30) begin msel[sec] = 1'b1; mwin = WIN; end
                else if (wdata == 8'hB0) begin mode = M_SUSP; mers = ERS; end
                else begin mode = M_IDLE; msel = 0; end
            end else if (mwin == 1) begin mode = M_ERASE; mers = ERS; end
            else mwin--;
        end else if (mode == M_ERASE) begin
            if (mers == 1) m_finish_erase();
            else begin
                mers--;
                if (wr_en && wdata == 8'hB0) begin mode = M_PEND; msus = SUS; end
            end
        end else if (mode == M_PEND) begin
            if (mers == 1) m_finish_erase();
            else begin
                mers--;
                if (msus == 1) mode = M_SUSP; else msus--;
            end
        end else if (mode == M_SUSP) begin
            if (wr_en && wdata == 8'h30) mode = M_ERASE;
        end
    endtask

    task automatic cyc();
        #1;
        last_rd = rdata;
        if (!rst) begin
            chk("MODEL busy", 32'(busy), 32'(mode == M_WIN || mode == M_ERASE || mode == M_PEND));
            chk("MODEL sel_vec", 32'(sel_vec), 32'(msel));
            chk("MODEL rdata", 32'(rdata), 32'(m_rdata()));
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int a, input int d, input int s);
        wr_en = 1; addr = 11'(a); wdata = 8'(d); sec = 3'(s);
        cyc();
        wr_en = 0; addr = 0; wdata = 0;
    endtask

    task automatic rd(input int s);
        rd_en = 1; sec = 3'(s);
        cyc();
        rd_en = 0;
    endtask

    task automatic erase_seq(input int s);
        wr('h555, 'hAA, 0); wr('h2AA, 'h55, 0); wr('h555, 'h80, 0);
        wr('h555, 'hAA, 0); wr('h2AA, 'h55, 0); wr(s * 64, 'h30, s);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin : stim
        logic [7:0] r_a;
        m_reset();
        rst = 1; wr_en = 0; rd_en = 0; addr = 0; sec = 0; wdata = 0; array_data = 8'h5A;
        cyc(); cyc();
        rst = 0;
        // R1 reset state
        #1;
        chk("R1 busy", 32'(busy), 0);
        chk("R1 sel_vec", 32'(sel_vec), 0);
        rd(2);
        chk("R1 read passes array", 32'(last_rd), 32'h5A);

        // R2 broken sequence: third write has wrong code
        wr('h555, 'hAA, 0); wr('h2AA, 'h55, 0); wr('h555, 'h90, 0);
        wr('h555, 'hAA, 0); wr('h2AA, 'h55, 0); wr(0, 'h30, 3);
        #1 chk("R2 broken sequence stays idle", 32'(busy), 0);

        // R2 full sequence
        erase_seq(3);
        #1;
        chk("R2 busy after sixth write", 32'(busy), 1);
        chk("R2 sel after sixth write", 32'(sel_vec), 32'h08);

        // R3 add sectors out of order
        wr(0, 'h30, 5); wr('h100, 'h30, 0);
        #1 chk("R3 accumulated set", 32'(sel_vec), 32'h29);
        idle(WIN - 1);
        rd(1);
        r_a = last_rd;
        chk("R5 dq3 low in last window cycle", 32'(last_rd & 8'h88), 0);
        rd(1);
        chk("R3 erase begins after window", 32'(last_rd & 8'h88), 32'h08);
        chk("R5 bit6 toggles between reads", 32'((last_rd ^ r_a) & 8'h40), 32'h40);

        // R6 ignored writes during erase
        wr('h555, 'hAA, 0); wr(0, 'h30, 6);
        #1;
        chk("R6 sel unchanged", 32'(sel_vec), 32'h29);
        chk("R6 still busy", 32'(busy), 1);

        // R8 suspend during erase with latency
        wr('h3FF, 'hB0, 0);
        idle(SUS - 1);
        #1 chk("R8 busy during suspend latency", 32'(busy), 1);
        idle(1);
        #1 chk("R8 suspended after latency", 32'(busy), 0);

        // R9 reads while suspended
        array_data = 8'hC3;
        rd(1);
        chk("R9 unselected returns array", 32'(last_rd), 32'hC3);
        rd(3);
        chk("R9 selected returns status", 32'(last_rd & 8'h88), 32'h08);

        // R10 resume
        wr(0, 'h30, 0);
        #1;
        chk("R10 busy after resume", 32'(busy), 1);
        chk("R10 set kept", 32'(sel_vec), 32'h29);

        // R11 completion
        idle(ERS);
        #1;
        chk("R11 busy low at end", 32'(busy), 0);
        chk("R11 sel cleared at end", 32'(sel_vec), 0);

        // R4 foreign write discards the set
        erase_seq(2);
        wr('h123, 'hF0, 0);
        #1;
        chk("R4 busy low after discard", 32'(busy), 0);
        chk("R4 sel cleared after discard", 32'(sel_vec), 0);

        // R7 suspend inside the window, arbitrary address
        erase_seq(4);
        wr('h7FF, 'hB0, 0);
        #1;
        chk("R7 suspended at once", 32'(busy), 0);
        chk("R7 set kept", 32'(sel_vec), 32'h10);
        rd(4);
        chk("R9 status for suspended sector", 32'(last_rd & 8'h88), 32'h08);
        wr(0, 'h30, 0);
        idle(ERS + 2);
        #1 chk("R11 full erase after window suspend", 32'(sel_vec), 0);

        // R12 reset mid-erase
        erase_seq(1);
        idle(WIN + 3);
        #1 chk("R12 erasing before reset", 32'(busy), 1);
        rst = 1;
        cyc();
        rst = 0;
        #1;
        chk("R12 busy low after reset", 32'(busy), 0);
        chk("R12 sel cleared after reset", 32'(sel_vec), 0);
        rd(1);
        chk("R12 array read after reset", 32'(last_rd), 32'hC3);

        done = 1;
        summary();
    end
endmodule